// File: doc/BRIEF.md
# Program Memory Lock Controller

This block guards an on-chip program flash with a set of non-volatile lock bits. The bits are decoded into a cumulative protection level. That level gates four kinds of access: code-table reads issued while execution runs from external program memory, flash programming, verify reads, and execution from external memory. Each access has a request input and a grant output. Every grant is combinational from its request and from the registered lock state. The memory and fetch logic uses a grant as a permit and treats its absence as a denial.

Lock bits are written through two command inputs. A set command programs one selected bit and can never clear one. A chip-erase command returns every bit to unprogrammed. Both commands take effect on the next clock edge. The lock bits have no reset: the hardware reset leaves them untouched, like the non-volatile cells they stand for.

While reset is held, the block samples the external-access pin on every clock and keeps the last sample once reset releases. When the first lock bit is programmed, that held value is used as the effective external-access level. A flag reports whenever the held value and the live pin disagree. No power-up initialisation is applied, so before the first reset the held value is arbitrary. All control pins are plain levels; the block has no data stream and no valid/ready handshake.

Top module: `code_lock_ctrl`

## Requirements
- R1: `prot_level` is 0 when no lock bit is set. Otherwise it is one plus the index of the highest set bit (bit 0 is the first lock bit), so bit 0 alone gives 1, bit 1 gives 2 and bit 2 gives 3. Combinations with gaps take the level of their highest bit.
- R2: `tbl_rd_grant` equals `tbl_rd_req`, except that it is 0 when `tbl_rd_ext` is 1 and `prot_level` is 1 or more.
- R3: `flash_pgm_grant` equals `flash_pgm_req` only at level 0; at any other level it is 0.
- R4: `verify_grant` equals `verify_req` at levels 0 and 1; at levels 2 and 3 it is 0.
- R5: `ext_exec_grant` equals `ext_exec_req` at levels 0 to 2; at level 3 it is 0.
- R6: When `lock_pgm_vld` is high and `chip_erase` is low, the bit of `lock_state` selected by `lock_pgm_sel` (0, 1 or 2) is set at the next edge and every other bit keeps its value. A select value of 3 changes nothing, and no set command ever clears a bit.
- R7: `chip_erase` clears all lock bits at the next edge. It takes priority over a set command in the same cycle, and it is the only way to clear a bit.
- R8: On every clock edge while `rst_n` is low, the held external-access value loads `ea_pin`. While `rst_n` is high, the held value does not change.
- R9: `ea_mismatch` is 1 exactly when lock bit 0 is set and the held external-access value differs from the live `ea_pin`.
- R10: `ea_effective` is the held value when lock bit 0 is set, and the live `ea_pin` when it is clear.
- R11: The lock bits keep their values through a hardware reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset; the pin is sampled while it is low |
| ea_pin | input | 1 | Live external-access pin level |
| lock_pgm_vld | input | 1 | Set-lock-bit command strobe |
| lock_pgm_sel | input | 2 | Index of the lock bit to set |
| chip_erase | input | 1 | Chip-erase command; clears all lock bits |
| tbl_rd_req | input | 1 | Code-table read request toward internal code memory |
| tbl_rd_ext | input | 1 | The table read comes from code executing externally |
| flash_pgm_req | input | 1 | Flash programming request |
| verify_req | input | 1 | Flash verify read request |
| ext_exec_req | input | 1 | Request to execute from external memory |
| tbl_rd_grant | output | 1 | Table read permitted |
| flash_pgm_grant | output | 1 | Programming permitted |
| verify_grant | output | 1 | Verify permitted |
| ext_exec_grant | output | 1 | External execution permitted |
| prot_level | output | 2 | Decoded protection level, 0 to 3 |
| lock_state | output | 3 | Current lock bits |
| ea_effective | output | 1 | External-access level the core should use |
| ea_mismatch | output | 1 | Held external-access value disagrees with the live pin |

## Verification
The hardest states to reach are those where the held external-access value differs from the live pin. The latch loads only while reset is asserted. To get there, the stimulus holds `ea_pin` at a chosen level through a reset pulse, releases reset, and then drives the opposite level. It does this for both polarities, with lock bit 0 set and with it clear. The gapped lock patterns (bit 1 or bit 2 without bit 0) cannot come about through the ordinary ascending programming order. The bench builds every one of the eight patterns by erasing and then programming bits in a chosen order. For each pattern it sweeps all 32 request combinations.

// File: rtl/code_lock_pkg.sv
package code_lock_pkg;
  typedef enum logic [1:0] {
    PL_OPEN  = 2'd0,
    PL_NOPGM = 2'd1,
    PL_NOVFY = 2'd2,
    PL_NOXEX = 2'd3
  } prot_lvl_e;

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lock_bit_store.sv
module lock_bit_store #(
  parameter int NBITS = 3,
  parameter int SEL_W = code_lock_pkg::sel_width(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_vld,
  input  logic [SEL_W-1:0] set_sel,
  input  logic             erase,
  output logic [NBITS-1:0] lock_q
);
  // Non-volatile cells: deliberately no reset term.
  for (genvar i = 0; i < NBITS; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (erase)
        lock_q[i] <= 1'b0;
      else if (set_vld && set_sel == SEL_W'(i))
        lock_q[i] <= 1'b1;
    end
  end

  p_no_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !erase |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  p_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (lock_q == '0));
endmodule

// File: rtl/lock_level_decode.sv
module lock_level_decode #(
  parameter int NBITS = 3,
  parameter int LVL_W = $clog2(NBITS + 1)
) (
  input  logic [NBITS-1:0] lock_q,
  output logic [LVL_W-1:0] level
);
  // The highest programmed bit decides the level.
  always_comb begin
    level = '0;
    for (int i = 0; i < NBITS; i++)
      if (lock_q[i]) level = LVL_W'(i + 1);
  end
endmodule

// File: rtl/ea_sample_latch.sv
module ea_sample_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ea_pin,
  output logic ea_held
);
  // Loads only while reset is held; no power-up value.
  always_ff @(posedge clk) begin
    if (!rst_n) ea_held <= ea_pin;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(ea_held));
endmodule

// File: rtl/code_lock_ctrl.sv
module code_lock_ctrl #(
  parameter int NUM_LOCK_BITS = 3,
  parameter int PGM_MAX_LVL   = int'(code_lock_pkg::PL_OPEN),
  parameter int VFY_MAX_LVL   = int'(code_lock_pkg::PL_NOPGM),
  parameter int XEX_MAX_LVL   = int'(code_lock_pkg::PL_NOVFY)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ea_pin,
  input  logic lock_pgm_vld,
  input  logic [code_lock_pkg::sel_width(NUM_LOCK_BITS)-1:0] lock_pgm_sel,
  input  logic chip_erase,
  input  logic tbl_rd_req,
  input  logic tbl_rd_ext,
  input  logic flash_pgm_req,
  input  logic verify_req,
  input  logic ext_exec_req,
  output logic tbl_rd_grant,
  output logic flash_pgm_grant,
  output logic verify_grant,
  output logic ext_exec_grant,
  output logic [$clog2(NUM_LOCK_BITS+1)-1:0] prot_level,
  output logic [NUM_LOCK_BITS-1:0] lock_state,
  output logic ea_effective,
  output logic ea_mismatch
);
  localparam int SEL_W = code_lock_pkg::sel_width(NUM_LOCK_BITS);
  localparam int LVL_W = $clog2(NUM_LOCK_BITS + 1);

  logic ea_held;

  lock_bit_store #(.NBITS(NUM_LOCK_BITS), .SEL_W(SEL_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vld (lock_pgm_vld),
    .set_sel (lock_pgm_sel),
    .erase   (chip_erase),
    .lock_q  (lock_state)
  );

  lock_level_decode #(.NBITS(NUM_LOCK_BITS), .LVL_W(LVL_W)) u_decode (
    .lock_q (lock_state),
    .level  (prot_level)
  );

  ea_sample_latch u_ea (
    .clk     (clk),
    .rst_n   (rst_n),
    .ea_pin  (ea_pin),
    .ea_held (ea_held)
  );

  always_comb begin
    tbl_rd_grant    = tbl_rd_req && !(tbl_rd_ext && prot_level != '0);
    flash_pgm_grant = flash_pgm_req && (int'(prot_level) <= PGM_MAX_LVL);
    verify_grant    = verify_req    && (int'(prot_level) <= VFY_MAX_LVL);
    ext_exec_grant  = ext_exec_req  && (int'(prot_level) <= XEX_MAX_LVL);
    ea_effective    = lock_state[0] ? ea_held : ea_pin;
    ea_mismatch     = lock_state[0] && (ea_held != ea_pin);
  end

  p_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_state == '0) |-> (prot_level == '0));

  p_tbl_deny_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd_ext && lock_state != '0) |-> !tbl_rd_grant);

  p_pgm_only_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flash_pgm_grant |-> (lock_state == '0));

  p_xex_deny_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_state[NUM_LOCK_BITS-1] |-> !ext_exec_grant);

  p_mismatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ea_mismatch |-> (lock_state[0] && ea_effective != ea_pin));
endmodule

// File: tb/code_lock_ctrl_bench.sv
module code_lock_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ea_pin = 1'b0;
  logic lock_pgm_vld = 1'b0;
  logic [1:0] lock_pgm_sel = 2'd0;
  logic chip_erase = 1'b0;
  logic tbl_rd_req = 1'b0, tbl_rd_ext = 1'b0, flash_pgm_req = 1'b0;
  logic verify_req = 1'b0, ext_exec_req = 1'b0;
  logic tbl_rd_grant, flash_pgm_grant, verify_grant, ext_exec_grant;
  logic [1:0] prot_level;
  logic [2:0] lock_state;
  logic ea_effective, ea_mismatch;

  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  code_lock_ctrl u_code_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin),
    .lock_pgm_vld(lock_pgm_vld), .lock_pgm_sel(lock_pgm_sel),
    .chip_erase(chip_erase), .tbl_rd_req(tbl_rd_req), .tbl_rd_ext(tbl_rd_ext),
    .flash_pgm_req(flash_pgm_req), .verify_req(verify_req),
    .ext_exec_req(ext_exec_req), .tbl_rd_grant(tbl_rd_grant),
    .flash_pgm_grant(flash_pgm_grant), .verify_grant(verify_grant),
    .ext_exec_grant(ext_exec_grant), .prot_level(prot_level),
    .lock_state(lock_state), .ea_effective(ea_effective),
    .ea_mismatch(ea_mismatch)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_level(input logic [2:0] lk);
    if (lk[2]) return 3;
    if (lk[1]) return 2;
    if (lk[0]) return 1;
    return 0;
  endfunction

  // One command cycle, driven on the falling edge.
  task automatic cmd(input logic pv, input logic [1:0] sel, input logic er);
    @(negedge clk);
    lock_pgm_vld = pv; lock_pgm_sel = sel; chip_erase = er;
    @(negedge clk);
    lock_pgm_vld = 1'b0; chip_erase = 1'b0;
  endtask

  task automatic load_locks(input logic [2:0] lk);
    cmd(1'b0, 2'd0, 1'b1);
    for (int b = 2; b >= 0; b--)
      if (lk[b]) cmd(1'b1, 2'(b), 1'b0);
  endtask

  task automatic pulse_reset(input logic pin);
    @(negedge clk);
    ea_pin = pin; rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // Erase while in reset so the lock cells hold known values.
    @(negedge clk);
    chip_erase = 1'b1;
    @(negedge clk);
    chip_erase = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R7 erased state", int'(lock_state), 0);
    check("R1 reset level", int'(prot_level), 0);

    // R1..R5: every lock pattern against every request combination.
    for (int lk = 0; lk < 8; lk++) begin
      load_locks(3'(lk));
      #1;
      check("R6 pattern built", int'(lock_state), lk);
      check("R1 level", int'(prot_level), exp_level(3'(lk)));
      for (int rq = 0; rq < 32; rq++) begin
        @(negedge clk);
        {tbl_rd_req, tbl_rd_ext, flash_pgm_req, verify_req, ext_exec_req} = 5'(rq);
        #1;
        begin
          int lv;
          lv = exp_level(3'(lk));
          check("R2 table read", int'(tbl_rd_grant),
                int'(tbl_rd_req && !(tbl_rd_ext && lv >= 1)));
          check("R3 program", int'(flash_pgm_grant), int'(flash_pgm_req && lv == 0));
          check("R4 verify", int'(verify_grant), int'(verify_req && lv <= 1));
          check("R5 ext exec", int'(ext_exec_grant), int'(ext_exec_req && lv <= 2));
        end
      end
      {tbl_rd_req, tbl_rd_ext, flash_pgm_req, verify_req, ext_exec_req} = 5'd0;
    end

    // R6: select 3 changes nothing; setting a set bit keeps it; no clearing.
    load_locks(3'b010);
    cmd(1'b1, 2'd3, 1'b0);
    #1 check("R6 select 3 ignored", int'(lock_state), 2);
    cmd(1'b1, 2'd1, 1'b0);
    #1 check("R6 re-set keeps bits", int'(lock_state), 2);
    cmd(1'b1, 2'd0, 1'b0);
    #1 check("R6 only addressed bit", int'(lock_state), 3);

    // R7: erase wins over a simultaneous set.
    cmd(1'b1, 2'd2, 1'b1);
    #1 check("R7 erase priority", int'(lock_state), 0);

    // R11: lock bits survive reset.
    load_locks(3'b101);
    pulse_reset(1'b0);
    #1 check("R11 locks through reset", int'(lock_state), 5);

    // R8/R9/R10: held value versus live pin, both polarities, LB1 on and off.
    for (int lb = 0; lb < 2; lb++) begin
      load_locks(lb != 0 ? 3'b001 : 3'b000);
      for (int held = 0; held < 2; held++) begin
        pulse_reset(1'(held));
        for (int pin = 0; pin < 2; pin++) begin
          @(negedge clk);
          ea_pin = 1'(pin);
          @(negedge clk);
          #1;
          check("R10 effective EA", int'(ea_effective), lb != 0 ? held : pin);
          check("R9 mismatch", int'(ea_mismatch), int'(lb != 0 && held != pin));
        end
      end
    end

    // R8: latch follows pin every clock in reset, last sample is held.
    load_locks(3'b001);
    @(negedge clk);
    rst_n = 1'b0; ea_pin = 1'b1;
    @(negedge clk);
    ea_pin = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; ea_pin = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R8 last reset sample held", int'(ea_effective), 0);
    check("R9 mismatch after hold", int'(ea_mismatch), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule